// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels gets the shared system bus. When an enabled channel asks for service, the arbiter raises a bus request and waits for the bus acknowledge. It then hands a one-hot grant to one of the pending channels. The channel's own engine moves the data and reports back with a completion strobe. That strobe is raised either when the transfer ends or when the channel's terminal count is reached.

A mode input picks how long the bus is held. In per-channel mode, the bus is given back as soon as the single granted channel finishes. In gather mode, the arbiter records every enabled request that is pending at the moment the bus is won. It grants those channels one after another, lowest index first, and keeps the bus until the last of them has finished. If the acknowledge drops during service, the grant is cut at once and the bus counts as lost.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `bus_req`, `grant` and `bus_release` are all 0, and no request is raised on the first cycle after reset.
- R2: A request on a channel whose `chan_en` bit is 0 never causes `bus_req` to rise and never receives a grant.
- R3: From idle, `bus_req` is 1 on the cycle after the first enabled request is sampled. It stays 1 until the bus is released or lost.
- R4: On the cycle after `bus_ack` is sampled high with `bus_req` raised, `grant` shows the lowest-index channel among the recorded requests. `grant` never has more than one bit set.
- R5: With `per_chan_mode` at 0, every enabled request present when `bus_ack` is sampled high is recorded. The recorded channels are granted in ascending index order, each after the previous one's `chan_done`, and the bus is held until the last one completes. Requests that arrive later are not granted during that hold.
- R6: With `per_chan_mode` at 1, only the lowest-index enabled request is recorded. The bus is released on the cycle after that channel's `chan_done`, even if other requests are pending.
- R7: A `chan_done` bit for a channel that is not currently granted has no effect on `grant`, `bus_req` or `bus_release`.
- R8: While `bus_ack` is 0, `grant` is 0 in the same cycle. If `bus_ack` falls during service, `bus_req` and `grant` are 0 from the next cycle and `bus_release` does not pulse.
- R9: `bus_release` is a one-cycle pulse in the cycle where `bus_req` first drops after a voluntary end of service. This includes the case where no enabled request is left when the bus is won.
- R10: After a release or a loss, `bus_req` is not raised again until `bus_ack` has been sampled at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_req | input | 4 | Per-channel service request |
| chan_en | input | 4 | Per-channel enable; a 0 masks that channel's request |
| per_chan_mode | input | 1 | 1: release after each channel; 0: serve all recorded requests |
| bus_ack | input | 1 | Bus acknowledge from the system bus owner |
| chan_done | input | 4 | Per-channel completion or terminal-count strobe |
| bus_req | output | 1 | Bus request |
| grant | output | 4 | One-hot service grant |
| bus_release | output | 1 | One-cycle pulse when the bus is handed back |

## Verification
In gather mode, the arbiter is driven with two simultaneous requests plus late arrivals. This separates a snapshot taken at acquisition from a live priority pick, and shows that the hold lasts until the last recorded channel completes. In per-channel mode, a masked channel is mixed with two enabled ones. This shows that the enable mask is honoured and that the bus is released after one channel even though another is still waiting. Directed cases then cover the rest:
- acknowledge loss in the middle of service, which separates an abort from a voluntary release;
- a request withdrawn before acknowledge, which must give a release with an empty grant;
- acknowledge held high after release, which must block a new request;
- completion strobes on channels that are not granted.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_en,
  input  logic           per_chan_mode,
  input  logic           bus_ack,
  input  logic [NCH-1:0] chan_done,
  output logic           bus_req,
  output logic [NCH-1:0] grant,
  output logic           bus_release
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_SERVE, ST_DRAIN} st_t;

  st_t            st;
  logic [NCH-1:0] pend_q, grant_q;
  logic           req_q, rel_q;

  function automatic logic [NCH-1:0] first_of(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    return r;
  endfunction

  logic [NCH-1:0] live, snap, left_after;
  logic           done_hit;

  assign live       = chan_req & chan_en;
  assign snap       = per_chan_mode ? first_of(live) : live;
  assign left_after = pend_q & ~grant_q;
  assign done_hit   = |(chan_done & grant_q);

  assign bus_req     = req_q;
  assign grant       = grant_q & {NCH{bus_ack}};
  assign bus_release = rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pend_q  <= '0;
      grant_q <= '0;
      req_q   <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      case (st)
        ST_IDLE:
          if (|live) begin
            req_q <= 1'b1;
            st    <= ST_ACQ;
          end
        ST_ACQ:
          if (bus_ack) begin
            if (|snap) begin
              pend_q  <= snap;
              grant_q <= first_of(snap);
              st      <= ST_SERVE;
            end else begin
              req_q <= 1'b0;
              rel_q <= 1'b1;
              st    <= ST_DRAIN;
            end
          end
        ST_SERVE:
          if (!bus_ack) begin
            pend_q  <= '0;
            grant_q <= '0;
            req_q   <= 1'b0;
            st      <= ST_DRAIN;
          end else if (done_hit) begin
            if (left_after == '0) begin
              pend_q  <= '0;
              grant_q <= '0;
              req_q   <= 1'b0;
              rel_q   <= 1'b1;
              st      <= ST_DRAIN;
            end else begin
              pend_q  <= left_after;
              grant_q <= first_of(left_after);
            end
          end
        default:
          if (!bus_ack) st <= ST_IDLE;
      endcase
    end
  end

  logic low_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                  low_seen <= 1'b1;
    else if (req_q)              low_seen <= 1'b0;
    else if (!bus_ack)           low_seen <= 1'b1;
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  assert_grant_in_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0) |-> ((grant_q & pend_q) != '0));

  assert_abort_on_ack_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0 && !bus_ack) |=> (grant_q == '0 && !req_q && !rel_q));

  assert_req_drop_reason_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> (rel_q || !$past(bus_ack)));

  assert_single_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && bus_ack && $countones(pend_q) == 1) |=> (rel_q && !req_q));

  assert_release_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> !rel_q);

  assert_reassert_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(low_seen));

  assert_masked_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && live == '0) |=> !req_q);

endmodule

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] chan_req, chan_en, chan_done, grant;
  logic       per_chan_mode, bus_ack, bus_req, bus_release;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_arbiter u_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_en(chan_en),
    .per_chan_mode(per_chan_mode), .bus_ack(bus_ack), .chan_done(chan_done),
    .bus_req(bus_req), .grant(grant), .bus_release(bus_release)
  );

  // {mode, en, req, ack, done, exp_req, exp_grant, exp_rel}
  localparam logic [19:0] VEC [0:NV-1] = '{
    {1'b0, 4'b1111, 4'b0000, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b0, 4'b1111, 4'b0110, 1'b0, 4'b0000, 1'b1, 4'b0000, 1'b0},
    {1'b0, 4'b1111, 4'b0110, 1'b0, 4'b0000, 1'b1, 4'b0000, 1'b0},
    {1'b0, 4'b1111, 4'b0110, 1'b1, 4'b0000, 1'b1, 4'b0010, 1'b0},
    {1'b0, 4'b1111, 4'b1111, 1'b1, 4'b0000, 1'b1, 4'b0010, 1'b0},
    {1'b0, 4'b1111, 4'b1111, 1'b1, 4'b0010, 1'b1, 4'b0100, 1'b0},
    {1'b0, 4'b1111, 4'b1111, 1'b1, 4'b1000, 1'b1, 4'b0100, 1'b0},
    {1'b0, 4'b1111, 4'b1111, 1'b1, 4'b0100, 1'b0, 4'b0000, 1'b1},
    {1'b0, 4'b1111, 4'b0000, 1'b1, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b0, 4'b1111, 4'b0000, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b0100, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b1100, 1'b0, 4'b0000, 1'b1, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b1, 4'b0000, 1'b1, 4'b0001, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b1, 4'b0001, 1'b0, 4'b0000, 1'b1},
    {1'b1, 4'b1011, 4'b1101, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b0, 4'b0000, 1'b1, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b1, 4'b0000, 1'b1, 4'b0001, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0},
    {1'b1, 4'b1011, 4'b1101, 1'b0, 4'b0000, 1'b1, 4'b0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic er, input logic [3:0] eg, input logic el);
    chk({tag, " bus_req"}, {3'b0, bus_req}, {3'b0, er});
    chk({tag, " grant"}, grant, eg);
    chk({tag, " bus_release"}, {3'b0, bus_release}, {3'b0, el});
  endtask

  task automatic drive(input logic m, input logic [3:0] en, input logic [3:0] rq,
                       input logic ak, input logic [3:0] dn);
    @(negedge clk);
    per_chan_mode = m; chan_en = en; chan_req = rq; bus_ack = ak; chan_done = dn;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; per_chan_mode = 1'b0; chan_en = 4'b1111; chan_req = 4'b1111;
    bus_ack = 1'b0; chan_done = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 reset", 1'b0, 4'b0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; chan_req = 4'b0000;

    // Table: R3/R4/R5/R7/R9/R10 in gather mode, then R2/R6/R8 in per-channel mode
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18:15], VEC[i][14:11], VEC[i][10], VEC[i][9:6]);
      chk_all($sformatf("R3-R10 vector %0d", i), VEC[i][5], VEC[i][4:1], VEC[i][0]);
    end

    // R9: requests withdrawn before acknowledge -> release with empty grant
    drive(1'b0, 4'b1111, 4'b0000, 1'b1, 4'b0000);
    chk_all("R9 empty snapshot", 1'b0, 4'b0000, 1'b1);
    drive(1'b0, 4'b1111, 4'b0000, 1'b0, 4'b0000);

    // R8: grant masked in the same cycle acknowledge falls
    drive(1'b0, 4'b1111, 4'b0001, 1'b0, 4'b0000);
    drive(1'b0, 4'b1111, 4'b0001, 1'b1, 4'b0000);
    chk_all("R4 grant ch0", 1'b1, 4'b0001, 1'b0);
    @(negedge clk);
    bus_ack = 1'b0;
    #1;
    chk("R8 grant masked", grant, 4'b0000);
    @(posedge clk);
    #1;
    chk_all("R8 abort", 1'b0, 4'b0000, 1'b0);

    // R10: acknowledge held high blocks a new request
    drive(1'b0, 4'b1111, 4'b0001, 1'b1, 4'b0000);
    chk_all("R10 ack high hold1", 1'b0, 4'b0000, 1'b0);
    drive(1'b0, 4'b1111, 4'b0001, 1'b1, 4'b0000);
    chk_all("R10 ack high hold2", 1'b0, 4'b0000, 1'b0);
    drive(1'b0, 4'b1111, 4'b0001, 1'b0, 4'b0000);
    chk_all("R10 ack low seen", 1'b0, 4'b0000, 1'b0);
    drive(1'b0, 4'b1111, 4'b0001, 1'b0, 4'b0000);
    chk_all("R10 reassert", 1'b1, 4'b0000, 1'b0);

    // R7: done on an ungranted channel, then R1 reset during service
    drive(1'b0, 4'b1111, 4'b0101, 1'b1, 4'b0000);
    chk_all("R5 gather start", 1'b1, 4'b0001, 1'b0);
    drive(1'b0, 4'b1111, 4'b0101, 1'b1, 4'b0100);
    chk_all("R7 foreign done", 1'b1, 4'b0001, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk_all("R1 reset mid service", 1'b0, 4'b0000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule